// File: doc/BRIEF.md
# DMA Datapath Enable Controller

This block sets the active or idle state of three DMA datapaths in an Ethernet MAC: one receive path and two transmit paths, a normal one and a real-time one. Each path has its own enable bit from the command register. Each path also has a `busy` level that is high while a packet is moving, and a `stat_done` pulse that marks the commit of that packet's status to memory. The per-path active outputs drive the descriptor engine directly and are also mirrored as status bits: 1 means active and 0 means idle.

Turning a path off is graceful. After its enable bit clears, a path stays active until the packet in flight has finished and its status has been committed. A transmit path also watches its descriptor ring. It becomes active only when the produce and consume indices differ. It drops to idle on its own as soon as they become equal, which means the ring is empty.

A synchronous soft reset forces every path to idle at the next clock edge. It does not wait for activity in flight, and it discards any record of a pending status write.

Top module: `dma_path_ctrl`

## Requirements
- R1: While `rst_ni` is low, all three active outputs are 0.
- R2: At a clock edge where `rx_en_i` is 1 and the receive path is idle, `rx_active_o` becomes 1 after that edge.
- R3: The receive path goes idle only when `rx_en_i` is 0 and the path is drained. Drained means that, at the same edge, `busy` is 0 and either no status is pending or `stat_done` is 1. Otherwise it stays active.
- R4: A status is pending from any edge that samples `busy` high until the edge that samples `stat_done` high with `busy` low. While a status is pending, a path with its enable clear stays active.
- R5: The normal transmit path (`tx_*`) and the real-time transmit path (`rt_*`) act independently. Inputs of one never change the active output of the other.
- R6: An idle transmit path becomes active after an edge only if, at that edge, its enable is 1 and its produce index differs from its consume index.
- R7: An active transmit path whose enable is 0 goes idle after the first edge at which it is drained (as in R3). Until then it stays active, as long as its ring is not empty.
- R8: An active transmit path goes idle after any edge at which its produce index equals its consume index, whatever its enable and busy inputs are.
- R9: Ring indices are compared as full-width unsigned values. Indices that differ only in their most significant bit count as a non-empty ring.
- R10: At an edge where `soft_rst_i` is 1, all three paths go idle and all pending status records are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset of all paths |
| rx_en_i | input | 1 | Receive path enable |
| rx_busy_i | input | 1 | Receive packet in flight |
| rx_stat_done_i | input | 1 | Receive status committed |
| tx_en_i | input | 1 | Normal transmit enable |
| tx_prod_idx_i | input | IDX_W | Normal ring produce index |
| tx_cons_idx_i | input | IDX_W | Normal ring consume index |
| tx_busy_i | input | 1 | Normal transmit packet in flight |
| tx_stat_done_i | input | 1 | Normal transmit status committed |
| rt_en_i | input | 1 | Real-time transmit enable |
| rt_prod_idx_i | input | IDX_W | Real-time ring produce index |
| rt_cons_idx_i | input | IDX_W | Real-time ring consume index |
| rt_busy_i | input | 1 | Real-time packet in flight |
| rt_stat_done_i | input | 1 | Real-time status committed |
| rx_active_o | output | 1 | Receive path active |
| tx_active_o | output | 1 | Normal transmit path active |
| rt_active_o | output | 1 | Real-time transmit path active |

## Verification
Every active output is a single register. A decision made from the inputs sampled at one rising edge therefore shows on the outputs right after that edge, one cycle after the stimulus was driven. The bench drives inputs on the falling edge and updates its reference model at the rising edge from those same inputs. It compares all three outputs on the next falling edge, so each result is checked exactly in the cycle it is due. The directed drain and soft-reset sequences hold their inputs for known numbers of edges. They check the state after each edge, which confirms the exact cycle in which a path drops.

// File: rtl/dma_path_pkg.sv
package dma_path_pkg;
  typedef enum logic {
    PATH_OFF = 1'b0,
    PATH_ON  = 1'b1
  } path_state_e;
endpackage

// File: rtl/dma_drain_trk.sv
module dma_drain_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic busy_i,
  input  logic stat_done_i,
  output logic drained_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (clr_i) pend_q <= 1'b0;
    else            pend_q <= busy_i | (pend_q & ~stat_done_i);
  end

  // drained this edge: nothing moving and status committed (or never owed)
  assign drained_o = ~busy_i & (~pend_q | stat_done_i);
endmodule

// File: rtl/dma_path_fsm.sv
module dma_path_fsm
  import dma_path_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter bit          IS_TX = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] prod_i,
  input  logic [IDX_W-1:0] cons_i,
  input  logic             busy_i,
  input  logic             stat_done_i,
  output logic             active_o
);
  path_state_e state_q, state_d;
  logic        drained;
  logic        ring_empty;

  dma_drain_trk u_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_rst_i),
    .busy_i      (busy_i),
    .stat_done_i (stat_done_i),
    .drained_o   (drained)
  );

  generate
    if (IS_TX) begin : g_ring
      assign ring_empty = (prod_i == cons_i);
    end else begin : g_noring
      logic unused_idx;
      assign unused_idx = ^{prod_i, cons_i};
      assign ring_empty = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PATH_OFF: if (en_i && !ring_empty) state_d = PATH_ON;
      PATH_ON:  if (ring_empty || (!en_i && drained)) state_d = PATH_OFF;
      default:  state_d = PATH_OFF;
    endcase
    if (soft_rst_i) state_d = PATH_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PATH_OFF;
    else         state_q <= state_d;
  end

  assign active_o = (state_q == PATH_ON);
endmodule

// File: rtl/dma_path_ctrl.sv
module dma_path_ctrl #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             rx_en_i,
  input  logic             rx_busy_i,
  input  logic             rx_stat_done_i,
  input  logic             tx_en_i,
  input  logic [IDX_W-1:0] tx_prod_idx_i,
  input  logic [IDX_W-1:0] tx_cons_idx_i,
  input  logic             tx_busy_i,
  input  logic             tx_stat_done_i,
  input  logic             rt_en_i,
  input  logic [IDX_W-1:0] rt_prod_idx_i,
  input  logic [IDX_W-1:0] rt_cons_idx_i,
  input  logic             rt_busy_i,
  input  logic             rt_stat_done_i,
  output logic             rx_active_o,
  output logic             tx_active_o,
  output logic             rt_active_o
);
  localparam int unsigned NUM_TX = 2;

  logic [NUM_TX-1:0]            t_en, t_busy, t_done, t_act;
  logic [NUM_TX-1:0][IDX_W-1:0] t_prod, t_cons;

  assign t_en   = {rt_en_i, tx_en_i};
  assign t_busy = {rt_busy_i, tx_busy_i};
  assign t_done = {rt_stat_done_i, tx_stat_done_i};
  assign t_prod = {rt_prod_idx_i, tx_prod_idx_i};
  assign t_cons = {rt_cons_idx_i, tx_cons_idx_i};

  dma_path_fsm #(.IDX_W(IDX_W), .IS_TX(1'b0)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .en_i        (rx_en_i),
    .prod_i      ('0),
    .cons_i      ('0),
    .busy_i      (rx_busy_i),
    .stat_done_i (rx_stat_done_i),
    .active_o    (rx_active_o)
  );

  for (genvar g = 0; g < NUM_TX; g++) begin : g_tx
    dma_path_fsm #(.IDX_W(IDX_W), .IS_TX(1'b1)) u_tx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .soft_rst_i  (soft_rst_i),
      .en_i        (t_en[g]),
      .prod_i      (t_prod[g]),
      .cons_i      (t_cons[g]),
      .busy_i      (t_busy[g]),
      .stat_done_i (t_done[g]),
      .active_o    (t_act[g])
    );
  end

  assign tx_active_o = t_act[0];
  assign rt_active_o = t_act[1];
endmodule

// File: rtl/dma_path_ctrl_chk.sv
module dma_path_ctrl_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic             rx_en_i,
  input logic             rx_busy_i,
  input logic             tx_en_i,
  input logic [IDX_W-1:0] tx_prod_idx_i,
  input logic [IDX_W-1:0] tx_cons_idx_i,
  input logic             tx_busy_i,
  input logic             rt_en_i,
  input logic [IDX_W-1:0] rt_prod_idx_i,
  input logic [IDX_W-1:0] rt_cons_idx_i,
  input logic             rx_active_o,
  input logic             tx_active_o,
  input logic             rt_active_o
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!rx_active_o && !tx_active_o && !rt_active_o);
    end
  end

  // R2
  rx_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_active_o) |-> $past(rx_en_i));

  // R4
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_active_o && rx_busy_i && !soft_rst_i) |=> rx_active_o);

  // R6
  tx_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_o) |-> $past(tx_en_i && (tx_prod_idx_i != tx_cons_idx_i)));

  // R6
  rt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rt_active_o) |-> $past(rt_en_i && (rt_prod_idx_i != rt_cons_idx_i)));

  // R7
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_o && tx_busy_i && (tx_prod_idx_i != tx_cons_idx_i) && !soft_rst_i)
    |=> tx_active_o);

  // R8
  tx_empty_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_prod_idx_i == tx_cons_idx_i) |=> !tx_active_o);

  // R8
  rt_empty_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_prod_idx_i == rt_cons_idx_i) |=> !rt_active_o);

  // R10
  soft_rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!rx_active_o && !tx_active_o && !rt_active_o));
endmodule

bind dma_path_ctrl dma_path_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .soft_rst_i    (soft_rst_i),
  .rx_en_i       (rx_en_i),
  .rx_busy_i     (rx_busy_i),
  .tx_en_i       (tx_en_i),
  .tx_prod_idx_i (tx_prod_idx_i),
  .tx_cons_idx_i (tx_cons_idx_i),
  .tx_busy_i     (tx_busy_i),
  .rt_en_i       (rt_en_i),
  .rt_prod_idx_i (rt_prod_idx_i),
  .rt_cons_idx_i (rt_cons_idx_i),
  .rx_active_o   (rx_active_o),
  .tx_active_o   (tx_active_o),
  .rt_active_o   (rt_active_o)
);

// File: tb/dma_path_ctrl_tb_top.sv
module dma_path_ctrl_tb_top;
  localparam int unsigned IDX_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic soft_rst_i = 1'b0;
  logic rx_en_i = 0, rx_busy_i = 0, rx_stat_done_i = 0;
  logic tx_en_i = 0, tx_busy_i = 0, tx_stat_done_i = 0;
  logic rt_en_i = 0, rt_busy_i = 0, rt_stat_done_i = 0;
  logic [IDX_W-1:0] tx_prod_idx_i = '0, tx_cons_idx_i = '0;
  logic [IDX_W-1:0] rt_prod_idx_i = '0, rt_cons_idx_i = '0;
  logic rx_active_o, tx_active_o, rt_active_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 0;

  // reference state: index 0 rx, 1 tx, 2 rt
  bit m_act[3];
  bit m_pend[3];

  always #2 clk_i = ~clk_i;

  dma_path_ctrl #(.IDX_W(IDX_W)) dut_i (.*);

  function automatic bit next_act(bit act, bit en, bit is_tx, bit empty, bit drained);
    if (!act) return en && !(is_tx && empty);
    if (is_tx && empty) return 1'b0;
    return !((!en) && drained);
  endfunction

  function automatic bit drained_f(bit busy, bit pend, bit sdone);
    return !busy && (!pend || sdone);
  endfunction

  task automatic model_edge();
    bit en[3], busy[3], sd[3], emp[3];
    en   = '{rx_en_i, tx_en_i, rt_en_i};
    busy = '{rx_busy_i, tx_busy_i, rt_busy_i};
    sd   = '{rx_stat_done_i, tx_stat_done_i, rt_stat_done_i};
    emp  = '{1'b0, tx_prod_idx_i == tx_cons_idx_i, rt_prod_idx_i == rt_cons_idx_i};
    for (int p = 0; p < 3; p++) begin
      if (soft_rst_i) begin
        m_act[p]  = 1'b0;
        m_pend[p] = 1'b0;
      end else begin
        m_act[p]  = next_act(m_act[p], en[p], p != 0, emp[p],
                             drained_f(busy[p], m_pend[p], sd[p]));
        m_pend[p] = busy[p] || (m_pend[p] && !sd[p]);
      end
    end
  endtask

  task automatic chk(string tag, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    chk({tag, " rx"}, rx_active_o, m_act[0]);
    chk({tag, " tx"}, tx_active_o, m_act[1]);
    chk({tag, " rt"}, rt_active_o, m_act[2]);
  endtask

  task automatic idle_all();
    rx_en_i = 0; tx_en_i = 0; rt_en_i = 0;
    rx_busy_i = 0; tx_busy_i = 0; rt_busy_i = 0;
    rx_stat_done_i = 0; tx_stat_done_i = 0; rt_stat_done_i = 0;
    tx_prod_idx_i = '0; tx_cons_idx_i = '0; rt_prod_idx_i = '0; rt_cons_idx_i = '0;
    soft_rst_i = 1;
    step("R10 clear");
    soft_rst_i = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    @(negedge clk_i);
    // R1 during reset
    chk("R1 rx", rx_active_o, 1'b0);
    chk("R1 tx", tx_active_o, 1'b0);
    chk("R1 rt", rt_active_o, 1'b0);
    rx_en_i = 1; tx_en_i = 1; tx_prod_idx_i = 4'd3;
    @(negedge clk_i);
    chk("R1 held rx", rx_active_o, 1'b0);
    chk("R1 held tx", tx_active_o, 1'b0);
    rx_en_i = 0; tx_en_i = 0; tx_prod_idx_i = '0;
    rst_ni = 1;
    @(negedge clk_i);

    // R2 / R3
    rx_en_i = 1;
    step("R2");
    chk("R2 rise", rx_active_o, 1'b1);
    rx_en_i = 0;
    step("R3");
    chk("R3 drop idle", rx_active_o, 1'b0);

    // R4 drain of receive
    rx_en_i = 1; rx_busy_i = 1;
    step("R4");
    rx_en_i = 0;
    step("R4"); chk("R4 busy hold", rx_active_o, 1'b1);
    rx_busy_i = 0;
    step("R4"); chk("R4 pend hold", rx_active_o, 1'b1);
    step("R4"); chk("R4 pend hold2", rx_active_o, 1'b1);
    rx_stat_done_i = 1;
    step("R4"); chk("R4 drop on commit", rx_active_o, 1'b0);
    rx_stat_done_i = 0;

    // R6 gating
    tx_en_i = 1;
    step("R6"); chk("R6 empty no rise", tx_active_o, 1'b0);
    tx_en_i = 0; tx_prod_idx_i = 4'd2;
    step("R6"); chk("R6 disabled no rise", tx_active_o, 1'b0);
    tx_en_i = 1;
    step("R6"); chk("R6 rise", tx_active_o, 1'b1);
    chk("R5 rt untouched", rt_active_o, 1'b0);

    // R7 drain of transmit
    tx_busy_i = 1;
    step("R7");
    tx_en_i = 0;
    step("R7"); chk("R7 busy hold", tx_active_o, 1'b1);
    tx_busy_i = 0; tx_stat_done_i = 1;
    step("R7"); chk("R7 drop", tx_active_o, 1'b0);
    tx_stat_done_i = 0;

    // R8 ring empties while busy and enabled
    tx_en_i = 1; tx_busy_i = 1;
    step("R8");
    tx_cons_idx_i = 4'd2;
    step("R8"); chk("R8 empty drop", tx_active_o, 1'b0);

    // R9 MSB-only difference on rt
    idle_all();
    rt_en_i = 1; rt_prod_idx_i = 4'b1000; rt_cons_idx_i = 4'b0000;
    step("R9"); chk("R9 msb nonempty", rt_active_o, 1'b1);
    chk("R5 tx untouched", tx_active_o, 1'b0);

    // R10 soft reset with traffic in flight
    rx_en_i = 1; rx_busy_i = 1; rt_busy_i = 1;
    step("R10");
    soft_rst_i = 1;
    step("R10"); chk("R10 rx", rx_active_o, 1'b0); chk("R10 rt", rt_active_o, 1'b0);
    soft_rst_i = 0; rx_en_i = 0; rx_busy_i = 0; rt_en_i = 0; rt_busy_i = 0;
    step("R10"); chk("R10 pend cleared", rx_active_o, 1'b0);

    // random mix
    idle_all();
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9) == 0) rx_en_i = ~rx_en_i;
      if ($urandom_range(9) == 0) tx_en_i = ~tx_en_i;
      if ($urandom_range(9) == 0) rt_en_i = ~rt_en_i;
      rx_busy_i = ($urandom_range(2) == 0);
      tx_busy_i = ($urandom_range(2) == 0);
      rt_busy_i = ($urandom_range(2) == 0);
      rx_stat_done_i = ($urandom_range(3) == 0);
      tx_stat_done_i = ($urandom_range(3) == 0);
      rt_stat_done_i = ($urandom_range(3) == 0);
      if ($urandom_range(5) == 0) tx_prod_idx_i = IDX_W'($urandom_range(3));
      if ($urandom_range(5) == 0) tx_cons_idx_i = IDX_W'($urandom_range(3));
      if ($urandom_range(5) == 0) rt_prod_idx_i = IDX_W'($urandom_range(3)) << (IDX_W - 2);
      if ($urandom_range(5) == 0) rt_cons_idx_i = IDX_W'($urandom_range(3)) << (IDX_W - 2);
      soft_rst_i = ($urandom_range(99) == 0);
      step("R5 random");
    end

    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule